// File: doc/BRIEF.md
# Undervoltage Limit Quantizer

This block holds the word that sets the undervoltage fault limit of a regulated output. A host writes and reads that limit as a 16-bit word on a simple register bus. The word is an absolute value in the same unsigned linear scale as the output-voltage target, so the two compare directly as integers. The threshold hardware only offers fixed fractions of the target. These run from 60 % to 95 % in 2.5 % steps, which gives level codes 0 to 14. After an accepted write, a sequential search picks the highest level whose threshold does not exceed the written word, so a value that falls between two levels is rounded down.

The block watches sampled output-voltage codes and compares each sample against the selected fraction of the live target. When the sample is low on two consecutive strobes, it raises a one-cycle fault pulse. A write outside the supported span is refused. The refusal sets a sticky invalid-data status bit, which drives an alert output until the host clears it. After reset, the limit word is taken from a default-value input instead of from non-volatile storage.

Top module: `uv_limit_quant`

## Requirements
- R1: Once the synchronised reset releases, the first clock loads the limit word from `dflt_limit` and starts a search. `busy` is high from reset through that search. `thr_code` is 0 until the search finishes. `alert` and `uv_fault` are low.
- R2: The limit word sits at bus address 0x44 and the status word at 0xD0, with the invalid-data flag in bit 0. `bus_rdata` shows the addressed word combinationally. Any other address reads 0, and writes to any other address are ignored.
- R3: A completed search sets `thr_code` to the highest k in 0..14 for which target×(240+10k) ≤ word×400. Code 0 means 60 % and code 14 means 95 %.
- R4: The search tests one level per clock. `busy` goes high in the cycle after an accepted write and stays high for exactly 15 cycles. `thr_code` changes only in the cycle in which `busy` falls. An accepted write during a search restarts the search from level 0.
- R5: A write to 0x44 whose value v gives v×400 < target×240 or v×400 > target×380 is refused. The stored word and `thr_code` stay unchanged, no search starts, and status bit 0 is set.
- R6: Status bit 0 is sticky. It clears only when 1 is written to bit 0 at 0xD0, and writing 0 there has no effect. `alert` equals the bit.
- R7: A change of `vout_target` alters neither the stored word nor `thr_code`. The comparison threshold follows the new target at once.
- R8: Reading 0x44 returns the last accepted word exactly as it was written, not the rounded level.
- R9: On each `smp_vld` strobe the sample counts as low when code×400 < target×(240+10×`thr_code`). `uv_fault` pulses for one cycle, in the cycle after the second consecutive low strobe. It pulses only once per run of low strobes. A strobe that is not low ends the run, and cycles without a strobe do not end it.
- R10: A strobe that falls on the same clock edge as the end of a search is judged against the level that was in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| dflt_limit | input | 16 | Limit word loaded after reset |
| vout_target | input | 16 | Current output-voltage target code |
| smp_vld | input | 1 | Output-voltage sample strobe |
| smp_code | input | 16 | Sampled output-voltage code |
| thr_code | output | 4 | Selected threshold level, 0 (60 %) to 14 (95 %) |
| busy | output | 1 | Load or level search in progress |
| alert | output | 1 | Host alert, follows the invalid-data flag |
| uv_fault | output | 1 | One-cycle undervoltage fault pulse |

## Verification
The level search and the fault filter can act on the same clock edge. In that case the edge that installs a new level also judges a sample, and the judgement must use the old level. The bench provokes this on purpose. It writes a much lower limit while the level is at its top, places one low strobe two cycles before the search ends, and places a second strobe exactly on the finishing edge. A fault pulse together with the new level code shows that the old threshold was used. A long pseudo-random phase then mixes writes during searches, target changes and strobes, so that the same collision recurs, and a behavioural model compares every output on every clock.

// File: rtl/uvq_pkg.sv
package uvq_pkg;

  // Consecutive-low run tracking for the sample filter
  typedef enum logic [1:0] {
    RUN_NONE = 2'd0,
    RUN_ONE  = 2'd1,
    RUN_TWO  = 2'd2
  } run_e;

  // Larger of two multipliers, used to size product widths
  function automatic int unsigned mul_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/uvq_rst_sync.sv
module uvq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;

endmodule

// File: rtl/uvq_regs.sv
module uvq_regs #(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 8,
  parameter logic [AW-1:0] LIM_ADDR  = 8'h44,
  parameter logic [AW-1:0] STAT_ADDR = 8'hD0,
  parameter int unsigned BASE      = 240,
  parameter int unsigned TOP_MUL   = 380,
  parameter int unsigned SCALE     = 400,
  parameter int unsigned MW        = 9,
  parameter int unsigned PW        = DW + MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] dflt,
  input  logic [DW-1:0] target,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] lim_q,
  output logic          ld_pend,
  output logic          inv_q,
  output logic          start
);

  logic [PW-1:0] w_scaled, lo_thr, hi_thr;
  logic          in_span, lim_wr, acc, rej, clr;
  logic [DW-1:0] lim_n;
  logic          lim_en, inv_n;

  assign w_scaled = PW'(bus_wdata) * PW'(SCALE);
  assign lo_thr   = PW'(target) * PW'(BASE);
  assign hi_thr   = PW'(target) * PW'(TOP_MUL);
  assign in_span  = (lo_thr <= w_scaled) && (w_scaled <= hi_thr);

  assign lim_wr = bus_wr && (bus_addr == LIM_ADDR) && !ld_pend;
  assign acc    = lim_wr && in_span;
  assign rej    = lim_wr && !in_span;
  assign clr    = bus_wr && (bus_addr == STAT_ADDR) && bus_wdata[0];
  assign start  = ld_pend || acc;

  always_comb begin
    lim_en = ld_pend || acc;
    lim_n  = ld_pend ? dflt : bus_wdata;
    inv_n  = inv_q;
    if (rej)      inv_n = 1'b1;
    else if (clr) inv_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= '0;
      ld_pend <= 1'b1;
      inv_q   <= 1'b0;
    end else begin
      if (lim_en) lim_q <= lim_n;
      ld_pend <= 1'b0;
      inv_q   <= inv_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == LIM_ADDR)       bus_rdata = lim_q;
    else if (bus_addr == STAT_ADDR) bus_rdata = {{(DW-1){1'b0}}, inv_q};
  end

  // R5
  rej_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> (lim_q == $past(lim_q)));
  // R5
  rej_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> inv_q);
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inv_q) |-> $past(clr));

endmodule

// File: rtl/uvq_search.sv
module uvq_search #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NLVL  = 15,
  parameter int unsigned BASE  = 240,
  parameter int unsigned STEP  = 10,
  parameter int unsigned SCALE = 400,
  parameter int unsigned MW    = 9,
  parameter int unsigned PW    = DW + MW,
  parameter int unsigned LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] lim,
  input  logic [DW-1:0] target,
  output logic          busy,
  output logic [LW-1:0] level
);

  logic          busy_q, busy_n;
  logic [LW-1:0] cnt_q, cnt_n, best_q, best_n, level_q, level_n;
  logic [MW-1:0] step_mul;
  logic          fits, last;

  assign step_mul = MW'(BASE) + MW'(STEP) * MW'(cnt_q);
  assign fits     = (PW'(target) * PW'(step_mul)) <= (PW'(lim) * PW'(SCALE));
  assign last     = (cnt_q == LW'(NLVL - 1));

  always_comb begin
    busy_n  = busy_q;
    cnt_n   = cnt_q;
    best_n  = best_q;
    level_n = level_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      best_n = '0;
    end else if (busy_q) begin
      if (last) begin
        level_n = fits ? cnt_q : best_q;
        busy_n  = 1'b0;
      end else begin
        best_n = fits ? cnt_q : best_q;
        cnt_n  = cnt_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      best_q  <= '0;
      level_q <= '0;
    end else begin
      busy_q  <= busy_n;
      cnt_q   <= cnt_n;
      best_q  <= best_n;
      level_q <= level_n;
    end
  end

  assign busy  = busy_q;
  assign level = level_q;

  // R4
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q)) |-> $stable(level_q));
  // R3
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(NLVL - 1));

endmodule

// File: rtl/uvq_detect.sv
module uvq_detect #(
  parameter int unsigned DW    = 16,
  parameter int unsigned BASE  = 240,
  parameter int unsigned STEP  = 10,
  parameter int unsigned SCALE = 400,
  parameter int unsigned MW    = 9,
  parameter int unsigned PW    = DW + MW,
  parameter int unsigned LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_code,
  input  logic [DW-1:0] target,
  input  logic [LW-1:0] level,
  output logic          fault
);
  import uvq_pkg::*;

  run_e          run_q, run_n;
  logic          fault_q, fault_n;
  logic [MW-1:0] lvl_mul;
  logic          below;

  assign lvl_mul = MW'(BASE) + MW'(STEP) * MW'(level);
  assign below   = (PW'(smp_code) * PW'(SCALE)) < (PW'(target) * PW'(lvl_mul));

  always_comb begin
    run_n   = run_q;
    fault_n = 1'b0;
    if (smp_vld) begin
      if (below) begin
        fault_n = (run_q == RUN_ONE);
        run_n   = (run_q == RUN_NONE) ? RUN_ONE : RUN_TWO;
      end else begin
        run_n = RUN_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= RUN_NONE;
      fault_q <= 1'b0;
    end else begin
      run_q   <= run_n;
      fault_q <= fault_n;
    end
  end

  assign fault = fault_q;

  // R9
  flt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> !fault_q);
  // R9
  flt_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> $past(smp_vld));

endmodule

// File: rtl/uv_limit_quant.sv
module uv_limit_quant #(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 8,
  parameter logic [AW-1:0] LIM_ADDR  = 8'h44,
  parameter logic [AW-1:0] STAT_ADDR = 8'hD0,
  parameter int unsigned NLVL      = 15,
  parameter int unsigned BASE      = 240,
  parameter int unsigned STEP      = 10,
  parameter int unsigned SCALE     = 400,
  parameter int unsigned LW        = $clog2(NLVL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] dflt_limit,
  input  logic [DW-1:0] vout_target,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_code,
  output logic [LW-1:0] thr_code,
  output logic          busy,
  output logic          alert,
  output logic          uv_fault
);
  import uvq_pkg::*;

  localparam int unsigned TOP_MUL = BASE + STEP * (NLVL - 1);
  localparam int unsigned MW      = $clog2(mul_max(SCALE, TOP_MUL) + 1);
  localparam int unsigned PW      = DW + MW;

  logic          rst_sn, ld_pend, inv_q, start, srch_busy;
  logic [DW-1:0] lim_q;
  logic [LW-1:0] level;

  uvq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  uvq_regs #(
    .DW(DW), .AW(AW), .LIM_ADDR(LIM_ADDR), .STAT_ADDR(STAT_ADDR),
    .BASE(BASE), .TOP_MUL(TOP_MUL), .SCALE(SCALE), .MW(MW), .PW(PW)
  ) u_regs (
    .clk(clk), .rst_n(rst_sn), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dflt(dflt_limit), .target(vout_target),
    .bus_rdata(bus_rdata), .lim_q(lim_q), .ld_pend(ld_pend),
    .inv_q(inv_q), .start(start)
  );

  uvq_search #(
    .DW(DW), .NLVL(NLVL), .BASE(BASE), .STEP(STEP), .SCALE(SCALE),
    .MW(MW), .PW(PW), .LW(LW)
  ) u_srch (
    .clk(clk), .rst_n(rst_sn), .start(start), .lim(lim_q),
    .target(vout_target), .busy(srch_busy), .level(level)
  );

  uvq_detect #(
    .DW(DW), .BASE(BASE), .STEP(STEP), .SCALE(SCALE),
    .MW(MW), .PW(PW), .LW(LW)
  ) u_det (
    .clk(clk), .rst_n(rst_sn), .smp_vld(smp_vld), .smp_code(smp_code),
    .target(vout_target), .level(level), .fault(uv_fault)
  );

  assign thr_code = level;
  assign busy     = srch_busy || ld_pend;
  assign alert    = inv_q;

  // R1
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ld_pend |=> srch_busy);

endmodule

// File: tb/sim_uv_limit_quant.sv
`timescale 1ns/1ps
module sim_uv_limit_quant;

  localparam int LIM_A  = 8'h44;
  localparam int STAT_A = 8'hD0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h44;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] dflt_limit = 16'd800;
  logic [15:0] vout_target = 16'd1000;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_code = '0;
  logic [3:0]  thr_code;
  logic        busy, alert, uv_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  uv_limit_quant u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dflt_limit(dflt_limit),
    .vout_target(vout_target), .smp_vld(smp_vld), .smp_code(smp_code),
    .thr_code(thr_code), .busy(busy), .alert(alert), .uv_fault(uv_fault)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1 = 0, m_s2 = 0;
  int m_ld = 1, m_lim = 0, m_inv = 0, m_busy = 0, m_k = 0, m_best = 0;
  int m_level = 0, m_run = 0, m_fault = 0;
  int acc_log[$];

  always @(posedge clk) begin
    longint t, w, c;
    int old_s2, acc, rej, ok, below;
    int n_lim, n_inv, n_busy, n_k, n_best, n_level, n_run, n_fault;
    old_s2 = m_s2;
    if (!rst_n) begin m_s1 = 0; m_s2 = 0; end
    else begin m_s2 = m_s1; m_s1 = 1; end
    if (old_s2 == 0) begin
      m_ld = 1; m_lim = 0; m_inv = 0; m_busy = 0; m_k = 0; m_best = 0;
      m_level = 0; m_run = 0; m_fault = 0;
    end else begin
      t = vout_target; w = bus_wdata; c = smp_code;
      acc = 0; rej = 0;
      if (bus_wr && bus_addr == LIM_A && !m_ld) begin
        if (t * 240 <= w * 400 && w * 400 <= t * 380) acc = 1; else rej = 1;
      end
      n_inv = m_inv;
      if (rej) n_inv = 1;
      else if (bus_wr && bus_addr == STAT_A && bus_wdata[0]) n_inv = 0;
      n_run = m_run; n_fault = 0;
      if (smp_vld) begin
        below = (c * 400 < t * (240 + 10 * m_level));
        if (below) begin
          n_fault = (m_run == 1);
          n_run = (m_run == 2) ? 2 : m_run + 1;
        end else n_run = 0;
      end
      n_busy = m_busy; n_k = m_k; n_best = m_best; n_level = m_level;
      if (m_ld || acc) begin
        n_busy = 1; n_k = 0; n_best = 0;
      end else if (m_busy) begin
        ok = (t * (240 + 10 * m_k) <= longint'(m_lim) * 400);
        if (m_k == 14) begin n_level = ok ? m_k : m_best; n_busy = 0; end
        else begin n_best = ok ? m_k : m_best; n_k = m_k + 1; end
      end
      n_lim = m_ld ? int'(dflt_limit) : (acc ? int'(bus_wdata) : m_lim);
      if (acc) acc_log.push_back(int'(bus_wdata));
      m_ld = 0; m_lim = n_lim; m_inv = n_inv; m_busy = n_busy; m_k = n_k;
      m_best = n_best; m_level = n_level; m_run = n_run; m_fault = n_fault;
    end
  end

  // compare every clock, 1 ns after the edge
  always @(posedge clk) begin
    int exp_rd;
    #1;
    if (cmp_en) begin
      exp_rd = (bus_addr == LIM_A) ? m_lim : (bus_addr == STAT_A) ? m_inv : 0;
      chk("R4 busy", busy, (m_busy || m_ld) ? 1 : 0);
      chk("R3 thr_code", thr_code, m_level);
      chk("R8 rdata", bus_rdata, exp_rd);
      chk("R6 alert", alert, m_inv);
      chk("R9 uv_fault", uv_fault, m_fault);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bwr(input int a, input int d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 16'(d);
    @(negedge clk); bus_wr = 1'b0; bus_addr = 8'(LIM_A);
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); bus_addr = 8'(a); #1; d = int'(bus_rdata);
  endtask

  task automatic strobe(input int code);
    @(negedge clk); smp_vld = 1'b1; smp_code = 16'(code);
    @(negedge clk); smp_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 40) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int d, n;
    logic [15:0] lf;
    int tgt;
    idle(3);
    chk("R1 busy in reset", busy, 1);
    chk("R1 alert in reset", alert, 0);
    @(negedge clk); rst_n = 1'b1;
    cmp_en = 1'b1;
    idle(1);
    chk("R1 busy after release", busy, 1);
    chk("R1 thr before search", thr_code, 0);
    idle(22);
    rd(LIM_A, d);   chk("R1 default word", d, 800);
    chk("R1 default level", thr_code, 8);
    chk("R1 fault low", uv_fault, 0);
    rd(STAT_A, d);  chk("R2 status read", d, 0);
    rd(8'h10, d);   chk("R2 other address", d, 0);
    bwr(8'h10, 16'h0001);
    rd(LIM_A, d);   chk("R2 write elsewhere ignored", d, 800);

    // R3, R4, R8
    bwr(LIM_A, 875);
    busy_len(n);    chk("R4 busy length", n, 15);
    chk("R3 87.5 percent", thr_code, 11);
    bwr(LIM_A, 613); idle(16);
    chk("R3 round down", thr_code, 0);
    rd(LIM_A, d);   chk("R8 exact word", d, 613);
    bwr(LIM_A, 625); idle(16); chk("R3 62.5 percent", thr_code, 1);
    bwr(LIM_A, 624); idle(16); chk("R3 just below step", thr_code, 0);
    bwr(LIM_A, 950); idle(16); chk("R3 top level", thr_code, 14);

    // R5, R6
    bwr(LIM_A, 599); #1;
    chk("R5 no search", busy, 0);
    chk("R5 alert set", alert, 1);
    rd(LIM_A, d);   chk("R5 word kept", d, 950);
    idle(16);       chk("R5 level kept", thr_code, 14);
    bwr(STAT_A, 0); chk("R6 zero write no clear", alert, 1);
    bwr(STAT_A, 1); chk("R6 clear by one", alert, 0);
    bwr(LIM_A, 951); chk("R5 above span", alert, 1);
    bwr(STAT_A, 1);

    // R9 at level 14, target 1000 -> threshold 950
    strobe(960);
    strobe(900); chk("R9 single low", uv_fault, 0);
    idle(1);
    strobe(900); chk("R9 second low", uv_fault, 1);
    strobe(900); chk("R9 once per run", uv_fault, 0);
    strobe(950); chk("R9 equal not low", uv_fault, 0);
    strobe(900); chk("R9 run restarted", uv_fault, 0);
    strobe(960); chk("R9 glitch filtered", uv_fault, 0);

    // R7
    @(negedge clk); vout_target = 16'd2000;
    idle(2);
    chk("R7 level kept", thr_code, 14);
    rd(LIM_A, d); chk("R7 word kept", d, 950);
    strobe(1500); strobe(1500);
    chk("R7 threshold follows target", uv_fault, 1);
    strobe(2000);
    @(negedge clk); vout_target = 16'd1000;
    strobe(960);

    // R10: strobe on the finishing edge of a search
    bwr(LIM_A, 600);
    idle(12);
    smp_vld = 1'b1; smp_code = 16'd800;
    @(negedge clk); smp_vld = 1'b0;
    @(negedge clk); smp_vld = 1'b1;
    chk("R10 still busy", busy, 1);
    @(negedge clk); smp_vld = 1'b0;
    chk("R10 old level judged", uv_fault, 1);
    chk("R10 new level in force", thr_code, 0);
    strobe(800); chk("R10 new level not low", uv_fault, 0);

    // R4 restart
    bwr(LIM_A, 777); idle(5);
    bwr(LIM_A, 900);
    busy_len(n); chk("R4 restart length", n, 15);
    chk("R4 restart level", thr_code, 12);
    chk("R8 accepted log", acc_log[acc_log.size()-1], 900);

    // pseudo-random mix
    lf = 16'hACE1; tgt = 1000;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bus_wr = 1'b0;
      bus_addr = lf[9] ? 8'(LIM_A) : 8'(STAT_A);
      case (lf[2:0])
        3'd0, 3'd1: begin
          bus_wr = 1'b1; bus_addr = 8'(LIM_A);
          bus_wdata = 16'((tgt * 55) / 100 + int'(lf) % ((tgt * 45) / 100 + 1));
        end
        3'd2: begin bus_wr = 1'b1; bus_addr = 8'(STAT_A); bus_wdata = {15'd0, lf[5]}; end
        3'd3: if (lf[6]) begin
          tgt = lf[4] ? 1200 : (lf[3] ? 800 : 1000);
          vout_target = 16'(tgt);
        end
        default: ;
      endcase
      smp_vld = lf[8];
      smp_code = 16'((tgt * 70) / 100 + int'(lf[15:7]) % ((tgt * 30) / 100));
    end
    @(negedge clk); bus_wr = 1'b0; smp_vld = 1'b0;
    idle(20);
    finish_run();
  end

endmodule